// File: doc/BRIEF.md
# Four-press sequence lock controller

This block watches a pair of push-button strobes, one for the digit 0 and one for the digit 1, and raises an open signal whenever the most recent four digits entered, taken in order, are 0, 1, 1, 0. There is no start key. Any suffix of the press history may complete the code, and a code may share presses with the one before it. After an opening, for example, the final 0 can already serve as the first digit of the next code.

The next state and the open flag are read from a lookup table. The table is addressed by the state code joined to the two button bits, in the way a small ROM would be organised, and is computed at elaboration time. Every state code the register can hold has an entry. The three codes the detector does not use lead to the idle state on the next clock, so the lock recovers from any power-up contents. Cycles with no key pressed leave the state unchanged, and so do cycles with both keys pressed. The open flag depends only on the current state. Debouncing and edge shaping of the buttons are done before this block, and so is driving the bolt.

Top module: `combo_lock`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state returns to idle (code 0), and `unlock` is 0 from the following cycle on.
- R2: `unlock` becomes 1 in the cycle after the edge that samples the fourth press of the ordered run 0,1,1,0. A press of the digit 0 is `btn0`=1 with `btn1`=0. A press of the digit 1 is `btn1`=1 with `btn0`=0.
- R3: Runs may overlap. After an opening, the presses 1,1,0 open the lock again, because the trailing 0 is reused.
- R4: Any single press taken while `unlock` is 1 clears `unlock` in the next cycle.
- R5: A cycle with `btn0`=0 and `btn1`=0 changes neither the state nor `unlock`, so gaps of any length may separate the presses.
- R6: A cycle with both `btn0` and `btn1` high is ignored. The state and `unlock` stay as they were, and the progress toward the code is kept.
- R7: The state codes 5, 6 and 7 give `unlock`=0 and move to idle on the next clock edge, whatever the buttons are. A 0 pressed in one of these codes therefore does not count as a first digit.
- R8: A wrong digit drops only the progress that no longer matches a suffix of the code. Both 0,1,0,1,1,0 and 0,0,1,1,0 open the lock, while 0,1,1,1 leaves it at idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to idle |
| btn0 | input | 1 | Single-cycle strobe for a press of digit 0 |
| btn1 | input | 1 | Single-cycle strobe for a press of digit 1 |
| unlock | output | 1 | High while the last four presses were 0,1,1,0 |

## Verification
The code is entered plainly, with idle gaps between the presses, with both-key cycles inserted, and as overlapping runs that reopen from the open state. These patterns separate a correct suffix-tracking detector from one that restarts after each opening, counts idle cycles or both-key cycles as presses, or loses its progress during a gap. Near-miss runs such as 0,1,0,1,1,0, 0,0,1,1,0 and 0,1,1,1 check that each wrong digit falls back to the right partial match. The register is also forced into each unused code, which shows whether a press taken there is wrongly treated as a first digit.

// File: rtl/lock_pkg.sv
package lock_pkg;

    localparam int STATE_W = 3;
    localparam int BTN_W   = 2;
    localparam int ADDR_W  = STATE_W + BTN_W;
    localparam int DEPTH   = 1 << ADDR_W;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE   = 3'd0,
        ST_GOT0   = 3'd1,
        ST_GOT01  = 3'd2,
        ST_GOT011 = 3'd3,
        ST_OPEN   = 3'd4
    } lock_state_e;

    // {btn1, btn0}
    typedef enum logic [BTN_W-1:0] {
        PR_NONE = 2'b00,
        PR_ZERO = 2'b01,
        PR_ONE  = 2'b10,
        PR_BOTH = 2'b11
    } press_e;

    typedef struct packed {
        logic [STATE_W-1:0] next;
        logic               open;
    } tbl_word_t;

    localparam int WORD_W = $bits(tbl_word_t);

    function automatic logic [STATE_W-1:0] step_zero(input logic [STATE_W-1:0] st);
        logic [STATE_W-1:0] nx;
        case (st)
            ST_GOT011: nx = ST_OPEN;
            default:   nx = ST_GOT0;
        endcase
        return nx;
    endfunction

    function automatic logic [STATE_W-1:0] step_one(input logic [STATE_W-1:0] st);
        logic [STATE_W-1:0] nx;
        case (st)
            ST_GOT0:  nx = ST_GOT01;
            ST_GOT01: nx = ST_GOT011;
            ST_OPEN:  nx = ST_GOT01;
            default:  nx = ST_IDLE;
        endcase
        return nx;
    endfunction

    function automatic logic legal_state(input logic [STATE_W-1:0] st);
        return st <= STATE_W'(ST_OPEN);
    endfunction

    function automatic tbl_word_t lock_entry(input logic [STATE_W-1:0] st,
                                             input logic [BTN_W-1:0]   pr);
        tbl_word_t w;
        w.open = (st == STATE_W'(ST_OPEN));
        if (!legal_state(st)) begin
            w.next = ST_IDLE;
        end else begin
            case (pr)
                PR_ZERO: w.next = step_zero(st);
                PR_ONE:  w.next = step_one(st);
                default: w.next = st;
            endcase
        end
        return w;
    endfunction

endpackage

// File: rtl/lock_press_decode.sv
module lock_press_decode
    import lock_pkg::*;
(
    input  logic   btn0,
    input  logic   btn1,
    output press_e press
);
    always_comb begin
        case ({btn1, btn0})
            2'b01:   press = PR_ZERO;
            2'b10:   press = PR_ONE;
            2'b11:   press = PR_BOTH;
            default: press = PR_NONE;
        endcase
    end
endmodule

// File: rtl/lock_table.sv
module lock_table
    import lock_pkg::*;
(
    input  logic [STATE_W-1:0] state,
    input  press_e             press,
    output tbl_word_t          word
);
    tbl_word_t rom [DEPTH];

    for (genvar a = 0; a < DEPTH; a++) begin : g_rom
        localparam logic [ADDR_W-1:0] ADDR = ADDR_W'(a);
        assign rom[a] = lock_entry(ADDR[ADDR_W-1:BTN_W], ADDR[BTN_W-1:0]);
    end

    logic [ADDR_W-1:0] addr;
    assign addr = {state, press};
    assign word = rom[addr];
endmodule

// File: rtl/lock_state_reg.sv
module lock_state_reg
    import lock_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [STATE_W-1:0] d,
    output logic [STATE_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= ST_IDLE;
        else     q <= d;
    end
endmodule

// File: rtl/combo_lock.sv
module combo_lock
    import lock_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic btn0,
    input  logic btn1,
    output logic unlock
);
    press_e             press;
    tbl_word_t          word;
    logic [STATE_W-1:0] state_q;

    lock_press_decode u_dec (
        .btn0  (btn0),
        .btn1  (btn1),
        .press (press)
    );

    lock_table u_tbl (
        .state (state_q),
        .press (press),
        .word  (word)
    );

    lock_state_reg u_state (
        .clk (clk),
        .rst (rst),
        .d   (word.next),
        .q   (state_q)
    );

    assign unlock = word.open;
endmodule

// File: rtl/combo_lock_chk.sv
module combo_lock_chk
    import lock_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               btn0,
    input logic               btn1,
    input logic               unlock,
    input logic [STATE_W-1:0] state
);
    logic [3:0] hist;
    logic [2:0] cnt;
    logic       single;
    logic       exp_open;

    assign single   = btn0 ^ btn1;
    assign exp_open = (cnt == 3'd4) && (hist == 4'b0110);

    always_ff @(posedge clk) begin
        if (rst || !legal_state(state)) begin
            hist <= '0;
            cnt  <= '0;
        end else if (single) begin
            hist <= {hist[2:0], btn1};
            if (cnt != 3'd4) cnt <= cnt + 3'd1;
        end
    end

    AST_RESET_CLOSED: assert property (@(posedge clk) rst |=> !unlock); // R1
    AST_OPEN_MATCHES_HISTORY: assert property (@(posedge clk) disable iff (rst)
        unlock == exp_open); // R2
    AST_REOPEN_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        (exp_open && cnt == 3'd4) |-> unlock); // R3
    AST_PRESS_CLEARS_OPEN: assert property (@(posedge clk) disable iff (rst)
        (unlock && single) |=> !unlock); // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!btn0 && !btn1 && legal_state(state)) |=> ($stable(state) && $stable(unlock))); // R5
    AST_BOTH_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (btn0 && btn1 && legal_state(state)) |=> $stable(state)); // R6
    AST_UNUSED_RECOVERS: assert property (@(posedge clk) disable iff (rst)
        !legal_state(state) |=> (state == STATE_W'(ST_IDLE))); // R7
    AST_UNUSED_CLOSED: assert property (@(posedge clk) disable iff (rst)
        !legal_state(state) |-> !unlock); // R7
    AST_WRONG_DIGIT: assert property (@(posedge clk) disable iff (rst)
        ((state == STATE_W'(ST_GOT011)) && btn1 && !btn0) |=> (state == STATE_W'(ST_IDLE))); // R8
endmodule

bind combo_lock combo_lock_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .btn0   (btn0),
    .btn1   (btn1),
    .unlock (unlock),
    .state  (state_q)
);

// File: tb/sim_combo_lock.sv
`timescale 1ns/1ps
module sim_combo_lock;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic btn0 = 1'b0;
    logic btn1 = 1'b0;
    logic unlock;
    int   n_chk = 0;
    int   n_bad = 0;

    always #10 clk = ~clk;

    combo_lock u0 (
        .clk    (clk),
        .rst    (rst),
        .btn0   (btn0),
        .btn1   (btn1),
        .unlock (unlock)
    );

    task automatic chk(input logic exp, input string tag);
        n_chk++;
        if (unlock !== exp) begin
            n_bad++;
            $display("FAIL %s: unlock=%b expected %b at %0t", tag, unlock, exp, $time);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic drive(input logic b1, input logic b0);
        btn1 = b1;
        btn0 = b0;
        @(negedge clk);
        btn1 = 1'b0;
        btn0 = 1'b0;
    endtask

    task automatic press(input logic digit, input logic exp, input string tag);
        drive(digit, ~digit);
        chk(exp, tag);
    endtask

    task automatic idle(input int n, input logic exp, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(exp, tag);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(1'b0, "R1 reset");
    endtask

    task automatic t_basic();
        do_reset();
        press(0, 0, "R2 first 0");
        press(1, 0, "R2 then 1");
        press(1, 0, "R2 then 1 again");
        press(0, 1, "R2 code complete");
    endtask

    task automatic t_overlap();
        idle(3, 1, "R5 open held with no press");
        press(1, 0, "R4 press clears open");
        press(1, 0, "R3 overlap second 1");
        press(0, 1, "R3 reopen on shared 0");
        press(0, 0, "R4 zero clears open");
        press(1, 0, "R3 after 00");
        press(1, 0, "R3 after 001");
        press(0, 1, "R3 reopen after 0 press");
    endtask

    task automatic t_reset_open();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(0, "R1 reset while open");
    endtask

    task automatic t_gaps();
        do_reset();
        press(0, 0, "R5 gap run 0");
        idle(4, 0, "R5 gap after 0");
        press(1, 0, "R5 gap run 1");
        idle(2, 0, "R5 gap after 01");
        press(1, 0, "R5 gap run 1b");
        idle(5, 0, "R5 gap after 011");
        press(0, 1, "R5 gap run opens");
    endtask

    task automatic t_both();
        do_reset();
        press(0, 0, "R6 run 0");
        press(1, 0, "R6 run 1");
        drive(1, 1);
        chk(0, "R6 both ignored mid run");
        press(1, 0, "R6 run 1b");
        drive(1, 1);
        chk(0, "R6 both ignored before last");
        press(0, 1, "R6 opens despite both");
        drive(1, 1);
        chk(1, "R6 both ignored while open");
        press(1, 0, "R6 open clears by single press");
    endtask

    task automatic t_wrong();
        do_reset();
        press(0, 0, "R8 a0");
        press(1, 0, "R8 a1");
        press(0, 0, "R8 a0 restart");
        press(1, 0, "R8 a1b");
        press(1, 0, "R8 a1c");
        press(0, 1, "R8 010110 opens");
        do_reset();
        press(0, 0, "R8 b0");
        press(0, 0, "R8 b00");
        press(1, 0, "R8 b1");
        press(1, 0, "R8 b1b");
        press(0, 1, "R8 00110 opens");
        do_reset();
        press(0, 0, "R8 c0");
        press(1, 0, "R8 c1");
        press(1, 0, "R8 c1b");
        press(1, 0, "R8 c0111 drops");
        press(1, 0, "R8 c1 idle");
        press(0, 0, "R8 c0 partial");
        press(0, 0, "R8 c00 no open");
    endtask

    task automatic t_recover(input logic [2:0] code);
        do_reset();
        force u0.u_state.q = code;
        #1;
        release u0.u_state.q;
        chk(0, "R7 unused code closed");
        press(0, 0, "R7 zero in unused code");
        press(1, 0, "R7 follow 1");
        press(1, 0, "R7 follow 1b");
        press(0, 0, "R7 zero not counted");
        press(1, 0, "R7 real run 1");
        press(1, 0, "R7 real run 1b");
        press(0, 1, "R7 real run opens");
    endtask

    task automatic t_recover_idle(input logic [2:0] code);
        do_reset();
        force u0.u_state.q = code;
        #1;
        release u0.u_state.q;
        idle(1, 0, "R7 unused code with no press");
        press(1, 0, "R7 idle after recovery");
        press(1, 0, "R7 idle after recovery b");
        press(0, 0, "R7 no stale progress");
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_basic();
        t_overlap();
        t_reset_open();
        t_gaps();
        t_both();
        t_wrong();
        t_recover(3'd5);
        t_recover(3'd6);
        t_recover(3'd7);
        t_recover_idle(3'd6);
        finish_run();
    end
endmodule